// File: doc/BRIEF.md
# Transaction-ID Replay Buffer

This block sits between a stream command decoder and a JTAG shifter and gives shift requests exactly-once behaviour over a transport that may drop replies. Each shift request carries an 8-bit transaction ID and the number of reply words it expects. When the ID differs from the one remembered, the request is executed: the shifter's TDO words are passed straight to the reply stream, and each word is also written into an internal RAM as it leaves. Once the final word has gone out, the ID and the number of words sent are committed as the remembered transaction.

When a request arrives whose ID equals the remembered one, the earlier reply was presumably lost. The block then refuses to touch JTAG again. It swallows the repeated request's payload up to its end marker and plays the stored words back onto the reply stream, marking the last one. If a request with a new ID needs more words than the RAM holds, it is refused and its payload is swallowed. The caller turns that refusal into an error reply. With a RAM depth of zero there is no storage and every request executes.

The controller is a five-state machine:
- `ST_IDLE` accepts a command and moves to one of three states:
  - `ST_EXEC` on a miss,
  - `ST_SKIP_PLAY` on an ID hit,
  - `ST_SKIP_DROP` on an oversize miss.
- `ST_EXEC` returns to `ST_IDLE` on the last TDO word.
- `ST_SKIP_PLAY` moves to `ST_PLAY` on the last payload word.
- `ST_SKIP_DROP` returns to `ST_IDLE` on the last payload word.
- `ST_PLAY` returns to `ST_IDLE` on the last stored word.

Top module: `replay_buffer`

## Requirements
- R1: After reset `cmd_ready` is 1 and `dec_valid`, `rep_valid`, `pay_ready` and `tdo_ready` are 0.
- R2: The first command after reset executes (decision code 2'b01) whatever its ID, including ID 0.
- R3: During execution, each TDO word appears on the reply stream in the same cycle with the same data and end marker. `tdo_ready` follows `rep_ready`, so a stalled reply stalls the shifter.
- R4: A command whose ID equals the last fully executed one gets decision code 2'b10. The stored words are then replayed in their original order, with `rep_last` on the final one. Data and marker are held while `rep_ready` is low.
- R5: A replay sends exactly the number of words the execution actually sent, even if the shifter ended early with fewer words than were requested.
- R6: In replay and refusal, payload words are accepted (`pay_ready`=1) up to and including the one with `pay_last`. No reply word is sent and `tdo_ready` stays 0 while this happens.
- R7: A command with a different ID executes, and then replaces the remembered ID and stored words.
- R8: With DEPTH>0, a non-matching command whose word count exceeds DEPTH gets decision code 2'b11. It sends no reply words and leaves the remembered ID and words intact.
- R9: With DEPTH=0, every command gets decision code 2'b01, including repeated IDs.
- R10: `dec_valid` is high for exactly the one cycle after a command is accepted. `cmd_ready` stays low from acceptance until the command's last word (reply, or payload for a refusal) has been transferred.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command present |
| cmd_ready | output | 1 | Command accepted when high with cmd_valid |
| cmd_id | input | ID_W | Transaction ID of the command |
| cmd_words | input | LEN_W | Number of reply words the command needs (at least 1) |
| dec_valid | output | 1 | One-cycle strobe carrying the decision |
| dec_kind | output | 2 | 01 execute, 10 replay, 11 refuse |
| pay_valid | input | 1 | Request payload word present |
| pay_last | input | 1 | Last payload word of the request |
| pay_ready | output | 1 | Payload word is being swallowed |
| tdo_valid | input | 1 | TDO word from the shifter present |
| tdo_data | input | WORD_W | TDO word |
| tdo_last | input | 1 | Last TDO word of the shift |
| tdo_ready | output | 1 | TDO word taken |
| rep_valid | output | 1 | Reply word present |
| rep_data | output | WORD_W | Reply word |
| rep_last | output | 1 | Last reply word |
| rep_ready | input | 1 | Reply word taken |

## Verification
The bench sweeps every request length from 1 to the full depth. Each length is executed under a fresh ID and then repeated under that ID, which shows whether stored words are written and read back at the right addresses and whether the end marker lands on the right word. A shift that ends early and is then repeated tells a replay sized by the stored count apart from one sized by the request. An oversize request followed by a repeat of the older ID shows that a refusal neither executes nor disturbs the stored transaction. A separate zero-depth instance given a repeated ID shows that execution is unconditional there.

// File: rtl/rpl_pkg.sv
package rpl_pkg;
    typedef enum logic [1:0] {
        DEC_NONE   = 2'b00,
        DEC_EXEC   = 2'b01,
        DEC_REPLAY = 2'b10,
        DEC_REJECT = 2'b11
    } dec_kind_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_EXEC,
        ST_SKIP_PLAY,
        ST_SKIP_DROP,
        ST_PLAY
    } rpl_state_e;
endpackage

// File: rtl/rpl_mem.sv
module rpl_mem #(
    parameter int DEPTH  = 16,
    parameter int WORD_W = 32,
    parameter int AW     = 4
) (
    input  logic              clk,
    input  logic              we,
    input  logic [AW-1:0]     waddr,
    input  logic [WORD_W-1:0] wdata,
    input  logic [AW-1:0]     raddr,
    output logic [WORD_W-1:0] rdata
);
    logic [WORD_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
    end

    assign rdata = mem[raddr];
endmodule

// File: rtl/rpl_tag.sv
module rpl_tag #(
    parameter int ENABLE = 1,
    parameter int ID_W   = 8,
    parameter int CNT_W  = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             set,
    input  logic [ID_W-1:0]  set_id,
    input  logic [CNT_W-1:0] set_cnt,
    input  logic [ID_W-1:0]  ask_id,
    output logic             hit,
    output logic [CNT_W-1:0] cnt
);
    generate
        if (ENABLE != 0) begin : g_tag
            logic [ID_W-1:0]  id_q;
            logic [CNT_W-1:0] cnt_q;
            logic             ok_q;

            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    id_q  <= '0;
                    cnt_q <= '0;
                    ok_q  <= 1'b0;
                end else if (set) begin
                    id_q  <= set_id;
                    cnt_q <= set_cnt;
                    ok_q  <= 1'b1;
                end else if (clr) begin
                    ok_q  <= 1'b0;
                end
            end

            assign hit = ok_q && (id_q == ask_id);
            assign cnt = cnt_q;
        end else begin : g_none
            assign hit = 1'b0;
            assign cnt = '0;
        end
    endgenerate
endmodule

// File: rtl/replay_buffer.sv
module replay_buffer
    import rpl_pkg::*;
#(
    parameter int WORD_W = 32,
    parameter int DEPTH  = 16,
    parameter int LEN_W  = 16,
    parameter int ID_W   = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    output logic              cmd_ready,
    input  logic [ID_W-1:0]   cmd_id,
    input  logic [LEN_W-1:0]  cmd_words,
    output logic              dec_valid,
    output logic [1:0]        dec_kind,
    input  logic              pay_valid,
    input  logic              pay_last,
    output logic              pay_ready,
    input  logic              tdo_valid,
    input  logic [WORD_W-1:0] tdo_data,
    input  logic              tdo_last,
    output logic              tdo_ready,
    output logic              rep_valid,
    output logic [WORD_W-1:0] rep_data,
    output logic              rep_last,
    input  logic              rep_ready
);
    localparam int CNT_W = (DEPTH > 0) ? $clog2(DEPTH + 1) : 1;
    localparam int AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam bit HAS_MEM = (DEPTH > 0);

    rpl_state_e       st_q, st_d;
    dec_kind_e        kind, kind_q;
    logic             dec_q;
    logic [ID_W-1:0]  cur_id_q;
    logic [CNT_W-1:0] ptr_q, set_cnt, stored_cnt;
    logic             hit, cmd_fire, rep_fire, pay_fire, exec_end, oversize;
    logic [WORD_W-1:0] mem_rdata;

    assign cmd_fire = cmd_valid && cmd_ready;
    assign rep_fire = rep_valid && rep_ready;
    assign pay_fire = pay_valid && pay_ready;
    assign exec_end = (st_q == ST_EXEC) && rep_fire && tdo_last;
    assign oversize = HAS_MEM && (32'(cmd_words) > DEPTH);
    assign set_cnt  = (32'(ptr_q) < DEPTH) ? ptr_q + 1'b1 : ptr_q;

    always_comb begin
        if (hit)           kind = DEC_REPLAY;
        else if (oversize) kind = DEC_REJECT;
        else               kind = DEC_EXEC;
    end

    rpl_tag #(.ENABLE(HAS_MEM ? 1 : 0), .ID_W(ID_W), .CNT_W(CNT_W)) u_tag (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (cmd_fire && (kind == DEC_EXEC)),
        .set     (exec_end),
        .set_id  (cur_id_q),
        .set_cnt (set_cnt),
        .ask_id  (cmd_id),
        .hit     (hit),
        .cnt     (stored_cnt)
    );

    generate
        if (HAS_MEM) begin : g_mem
            rpl_mem #(.DEPTH(DEPTH), .WORD_W(WORD_W), .AW(AW)) u_mem (
                .clk   (clk),
                .we    ((st_q == ST_EXEC) && rep_fire && (32'(ptr_q) < DEPTH)),
                .waddr (ptr_q[AW-1:0]),
                .wdata (tdo_data),
                .raddr (ptr_q[AW-1:0]),
                .rdata (mem_rdata)
            );
        end else begin : g_nomem
            assign mem_rdata = '0;
        end
    endgenerate

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= ST_IDLE;
        else        st_q <= st_d;
    end

    // Next-state logic
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_IDLE: if (cmd_fire) begin
                unique case (kind)
                    DEC_REPLAY: st_d = ST_SKIP_PLAY;
                    DEC_REJECT: st_d = ST_SKIP_DROP;
                    default:    st_d = ST_EXEC;
                endcase
            end
            ST_EXEC:      if (exec_end) st_d = ST_IDLE;
            ST_SKIP_PLAY: if (pay_fire && pay_last) st_d = ST_PLAY;
            ST_SKIP_DROP: if (pay_fire && pay_last) st_d = ST_IDLE;
            ST_PLAY:      if (rep_fire && rep_last) st_d = ST_IDLE;
            default:      st_d = ST_IDLE;
        endcase
    end

    // Datapath registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dec_q    <= 1'b0;
            kind_q   <= DEC_NONE;
            cur_id_q <= '0;
            ptr_q    <= '0;
        end else begin
            dec_q <= cmd_fire;
            if (cmd_fire) begin
                kind_q   <= kind;
                cur_id_q <= cmd_id;
                ptr_q    <= '0;
            end else if (rep_fire && (32'(ptr_q) < DEPTH)) begin
                ptr_q <= ptr_q + 1'b1;
            end
        end
    end

    // Outputs
    always_comb begin
        cmd_ready = 1'b0;
        pay_ready = 1'b0;
        tdo_ready = 1'b0;
        rep_valid = 1'b0;
        rep_data  = '0;
        rep_last  = 1'b0;
        unique case (st_q)
            ST_IDLE: cmd_ready = 1'b1;
            ST_EXEC: begin
                tdo_ready = rep_ready;
                rep_valid = tdo_valid;
                rep_data  = tdo_data;
                rep_last  = tdo_last;
            end
            ST_SKIP_PLAY, ST_SKIP_DROP: pay_ready = 1'b1;
            ST_PLAY: begin
                rep_valid = 1'b1;
                rep_data  = mem_rdata;
                rep_last  = (ptr_q == stored_cnt - 1'b1);
            end
            default: ;
        endcase
    end

    assign dec_valid = dec_q;
    assign dec_kind  = kind_q;
endmodule

// File: rtl/rpl_checker.sv
module rpl_checker #(
    parameter int WORD_W = 32,
    parameter int DEPTH  = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cmd_valid,
    input logic              cmd_ready,
    input logic              dec_valid,
    input logic [1:0]        dec_kind,
    input logic              pay_ready,
    input logic              tdo_ready,
    input logic              rep_valid,
    input logic [WORD_W-1:0] rep_data,
    input logic              rep_last,
    input logic              rep_ready
);
    // R10: decision strobe follows acceptance for one cycle
    p_dec_follows_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_ready) |=> (dec_valid && !cmd_ready));
    p_dec_single_r10: assert property (@(posedge clk) disable iff (!rst_n)
        dec_valid |=> !dec_valid);
    // R6: no reply and no shifting while payload is swallowed
    p_drain_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
        pay_ready |-> (!rep_valid && !tdo_ready));
    // R4: stalled reply word held
    p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (rep_valid && !rep_ready) |=> (rep_valid && $stable(rep_data) && $stable(rep_last)));
    // R8: refusal sends nothing in its decision cycle
    p_reject_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_valid && dec_kind == 2'b11) |-> !rep_valid);
    p_kind_defined_r10: assert property (@(posedge clk) disable iff (!rst_n)
        dec_valid |-> (dec_kind != 2'b00));
    generate
        if (DEPTH == 0) begin : g_z
            // R9: no memory means unconditional execution
            p_always_exec_r9: assert property (@(posedge clk) disable iff (!rst_n)
                dec_valid |-> (dec_kind == 2'b01));
        end
    endgenerate
endmodule

bind replay_buffer rpl_checker #(.WORD_W(WORD_W), .DEPTH(DEPTH)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmd_valid (cmd_valid),
    .cmd_ready (cmd_ready),
    .dec_valid (dec_valid),
    .dec_kind  (dec_kind),
    .pay_ready (pay_ready),
    .tdo_ready (tdo_ready),
    .rep_valid (rep_valid),
    .rep_data  (rep_data),
    .rep_last  (rep_last),
    .rep_ready (rep_ready)
);

// File: tb/tb_replay_buffer.sv
module tb_replay_buffer;
    localparam int CLK_PERIOD = 10;
    localparam int W  = 16;
    localparam int D  = 8;
    localparam int LW = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #(CLK_PERIOD/2) clk = ~clk;

    logic cmd_valid = 0, pay_valid = 0, pay_last = 0, tdo_valid = 0, tdo_last = 0, rep_ready = 1;
    logic [7:0] cmd_id = 0;
    logic [LW-1:0] cmd_words = 0;
    logic [W-1:0] tdo_data = 0;
    logic cmd_ready, dec_valid, pay_ready, tdo_ready, rep_valid, rep_last;
    logic [1:0] dec_kind;
    logic [W-1:0] rep_data;

    replay_buffer #(.WORD_W(W), .DEPTH(D), .LEN_W(LW), .ID_W(8)) dut (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
        .cmd_id(cmd_id), .cmd_words(cmd_words), .dec_valid(dec_valid), .dec_kind(dec_kind),
        .pay_valid(pay_valid), .pay_last(pay_last), .pay_ready(pay_ready),
        .tdo_valid(tdo_valid), .tdo_data(tdo_data), .tdo_last(tdo_last), .tdo_ready(tdo_ready),
        .rep_valid(rep_valid), .rep_data(rep_data), .rep_last(rep_last), .rep_ready(rep_ready));

    // zero-depth instance with its own stimulus
    logic z_cmd_valid = 0, z_tdo_valid = 0;
    logic [W-1:0] z_tdo_data = 0;
    logic z_cmd_ready, z_dec_valid, z_pay_ready, z_tdo_ready, z_rep_valid, z_rep_last;
    logic [1:0] z_dec_kind;
    logic [W-1:0] z_rep_data;

    replay_buffer #(.WORD_W(W), .DEPTH(0), .LEN_W(LW), .ID_W(8)) dut_z (
        .clk(clk), .rst_n(rst_n), .cmd_valid(z_cmd_valid), .cmd_ready(z_cmd_ready),
        .cmd_id(8'd3), .cmd_words(8'd1), .dec_valid(z_dec_valid), .dec_kind(z_dec_kind),
        .pay_valid(1'b0), .pay_last(1'b0), .pay_ready(z_pay_ready),
        .tdo_valid(z_tdo_valid), .tdo_data(z_tdo_data), .tdo_last(1'b1), .tdo_ready(z_tdo_ready),
        .rep_valid(z_rep_valid), .rep_data(z_rep_data), .rep_last(z_rep_last), .rep_ready(1'b1));

    int total = 0, fails = 0;

    // bench model of stored transaction
    logic [W-1:0] store [D];
    logic [7:0]   m_id = 0;
    bit           m_ok = 0;
    int           m_cnt = 0;

    function automatic logic [W-1:0] dval(int id, int i);
        return W'(id * 97 + i * 13 + 16'h3C00);
    endfunction

    task automatic chk(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
        total++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // runs one command; sent = TDO words delivered if executed, drain = payload words if skipped
    task automatic run_cmd(int id, int words, int sent, int drain, string tag);
        logic [1:0] ek;
        if (m_ok && m_id == 8'(id)) ek = 2'b10;
        else if (words > D)         ek = 2'b11;
        else                        ek = 2'b01;
        cmd_valid = 1; cmd_id = 8'(id); cmd_words = LW'(words);
        #1 chk(cmd_ready == 1, {tag, " R10 cmd_ready"}, 32'(cmd_ready), 1);
        @(posedge clk); @(negedge clk);
        cmd_valid = 0;
        #1 chk(dec_valid == 1 && dec_kind == ek, {tag, " decision"}, {dec_valid, dec_kind}, {1'b1, ek});
        if (ek == 2'b01) begin
            for (int i = 0; i < sent; i++) begin
                tdo_valid = 1; tdo_data = dval(id, i); tdo_last = (i == sent - 1);
                if (i == 0) begin
                    rep_ready = 0;
                    #1 chk(tdo_ready == 0 && rep_valid == 1, "R3 stall", {tdo_ready, rep_valid}, 2'b01);
                    @(posedge clk); @(negedge clk);
                    rep_ready = 1;
                end
                #1 chk(rep_valid && tdo_ready && rep_data == dval(id, i) && rep_last == (i == sent - 1),
                       "R3 mirror", rep_data, dval(id, i));
                store[i] = dval(id, i);
                @(posedge clk); @(negedge clk);
            end
            tdo_valid = 0; tdo_last = 0;
            m_ok = 1; m_id = 8'(id); m_cnt = sent;
        end else begin
            for (int j = 0; j < drain; j++) begin
                pay_valid = 1; pay_last = (j == drain - 1);
                #1 chk(pay_ready && !rep_valid && !tdo_ready, "R6 drain", {pay_ready, rep_valid, tdo_ready}, 3'b100);
                @(posedge clk); @(negedge clk);
            end
            pay_valid = 0; pay_last = 0;
            if (ek == 2'b10) begin
                for (int i = 0; i < m_cnt; i++) begin
                    if (i == 0) begin
                        rep_ready = 0;
                        @(posedge clk); @(negedge clk);
                        rep_ready = 1;
                    end
                    #1 chk(rep_valid && rep_data == store[i] && rep_last == (i == m_cnt - 1),
                           {tag, " R4 replay word"}, {rep_last, rep_data}, {(i == m_cnt - 1), store[i]});
                    @(posedge clk); @(negedge clk);
                end
            end else begin
                #1 chk(!rep_valid, "R8 no reply", 32'(rep_valid), 0);
            end
        end
        #1 chk(cmd_ready == 1 && !rep_valid, {tag, " R10 back to idle"}, {cmd_ready, rep_valid}, 2'b10);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        total++; fails++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1;
        #1 chk(cmd_ready && !dec_valid && !rep_valid && !pay_ready && !tdo_ready, "R1 reset",
               {cmd_ready, dec_valid, rep_valid, pay_ready, tdo_ready}, 5'b10000);
        run_cmd(0, 3, 3, 0, "R2");
        run_cmd(0, 3, 0, 2, "R4");
        for (int n = 1; n <= D; n++) begin
            run_cmd(n + 16, n, n, 0, "R7");
            run_cmd(n + 16, n, 0, n, "R4");
        end
        run_cmd(8'h40, 6, 2, 0, "R5");
        run_cmd(8'h40, 6, 0, 3, "R5");
        run_cmd(8'h55, 9, 0, 2, "R8");
        run_cmd(8'h40, 6, 0, 1, "R8");
        run_cmd(8'h55, 4, 4, 0, "R7");
        run_cmd(8'h55, 4, 0, 1, "R4");
        // R9: zero depth, same ID twice
        for (int k = 0; k < 2; k++) begin
            @(negedge clk);
            z_cmd_valid = 1;
            @(posedge clk); @(negedge clk);
            z_cmd_valid = 0; z_tdo_valid = 1; z_tdo_data = dval(3, k);
            #1 chk(z_dec_valid && z_dec_kind == 2'b01, "R9 exec", z_dec_kind, 2'b01);
            chk(z_rep_valid && z_rep_data == dval(3, k) && z_rep_last, "R9 mirror", z_rep_data, dval(3, k));
            @(posedge clk); @(negedge clk);
            z_tdo_valid = 0;
        end
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end
endmodule